// File: doc/BRIEF.md
# Lane High-Speed Transmit Sequencer

This block is the transmit-side lane controller that sits between a protocol layer and a serial lane. The protocol side uses a word clock, a 16-bit word bus, a request input and a ready output. When the protocol raises the request, and the clock lane is already active, the block runs a fixed start-up sequence before it raises ready. The sequence is two low-power escape periods, a prepare period, a zero period and a clock-crossing wait, and each period has a length set in word-clock cycles.

Once ready is high, one word is taken on every clock edge where the request is still high. Each word taken appears on the output word bus, with a valid flag, one cycle later. The protocol ends the burst by lowering the request. Ready then falls, the lane spends a set number of cycles in a trail state and then returns to Stop. If the request is withdrawn during start-up, the lane drops back to Stop at once and no word is taken.

States and transitions, in the 3-bit lane state code: STOP (0) goes to LP_REQ (1) when the request and the clock-lane input are both high. LP_REQ goes to LP_BRIDGE (2), then to HS_PREPARE (3), then to HS_ZERO (4), then to CDC_WAIT (5), then to HS_DATA (6), each step taken when its period expires. Any start-up state goes back to STOP when the request is low. HS_DATA goes to HS_TRAIL (7) when the request is low. HS_TRAIL goes to STOP when its period expires.

Top module: `hs_lane_tx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, lane_state is 0 (STOP), ready is 0 and out_valid is 0.
- R2: In STOP, the request is ignored while clk_lane_active is low: the lane stays at code 0. Start-up begins only on an edge where the request and clk_lane_active are both high.
- R3: Start-up visits codes 1, 2, 3, 4 and 5 in that order. They last LPX, LPX, PREP, ZERO and CDC_FIX+2 cycles. Ready first reads high 2·LPX+PREP+ZERO+CDC_FIX+2+1 edges after the request was first sampled high in STOP.
- R4: The lane state code is 6 while ready is high and words are being taken, and 7 during the trail.
- R5: A word is taken on each edge where ready and the request are both high. It appears on out_word with out_valid high in the next cycle, in the order it was taken.
- R6: While the request is low, hs_data is ignored: out_valid stays 0 and out_word keeps its last value.
- R7: Ready stays high for as long as the request is high in HS_DATA. It falls only in the cycle after the edge where the request was sampled low.
- R8: After the request is withdrawn in HS_DATA, the lane shows code 7 for TRAIL cycles and then returns to 0.
- R9: If the request is low at any edge during start-up (codes 1 to 5), the lane is at code 0 in the next cycle. Ready is never raised and no word is output.
- R10: A burst of a single word is taken and output like a longer one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_lane_active | input | 1 | High when the clock lane is in high-speed mode |
| hs_req | input | 1 | Request for a high-speed burst from the protocol |
| hs_data | input | W | Word offered by the protocol |
| hs_ready | output | 1 | Lane takes hs_data on this edge if hs_req is high |
| lane_state | output | 3 | Current lane state code (0 to 7) |
| out_word | output | W | Last word taken |
| out_valid | output | 1 | out_word was taken on the previous edge |

## Verification
Bursts of one to six words, each with its own data pattern, are sent with the expected state code worked out for every start-up cycle. This separates errors in the period lengths from errors in the order of the states. The request is withdrawn once at every possible start-up cycle, which shows whether the abort path covers each state and leaves no word behind. A request made while the clock lane is inactive shows whether start-up is gated. Changing hs_data during the trail and in Stop shows whether data is ignored while the request is low.

// File: rtl/hs_lane_pkg.sv
package hs_lane_pkg;

    typedef enum logic [2:0] {
        LS_STOP      = 3'd0,
        LS_LP_REQ    = 3'd1,
        LS_LP_BRIDGE = 3'd2,
        LS_HS_PREP   = 3'd3,
        LS_HS_ZERO   = 3'd4,
        LS_CDC_WAIT  = 3'd5,
        LS_HS_DATA   = 3'd6,
        LS_HS_TRAIL  = 3'd7
    } lane_state_e;

endpackage

// File: rtl/hs_lane_timer.sv
module hs_lane_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // The counter never runs below zero (supports R3, R8).
    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(load) && $past(cnt) == '0) |-> cnt == '0);

endmodule

// File: rtl/hs_lane_seq.sv
module hs_lane_seq
    import hs_lane_pkg::*;
#(
    parameter int LPX     = 2,
    parameter int PREP    = 1,
    parameter int ZERO    = 3,
    parameter int CDC_FIX = 1,
    parameter int TRAIL   = 2,
    parameter int CW      = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hs_req,
    input  logic          clk_lane_active,
    input  logic          tmr_expired,
    output lane_state_e   state,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          hs_ready,
    output logic          accept
);

    localparam logic [CW-1:0] LPX_M1   = CW'(LPX - 1);
    localparam logic [CW-1:0] PREP_M1  = CW'(PREP - 1);
    localparam logic [CW-1:0] ZERO_M1  = CW'(ZERO - 1);
    localparam logic [CW-1:0] CDC_M1   = CW'(CDC_FIX + 2 - 1);
    localparam logic [CW-1:0] TRAIL_M1 = CW'(TRAIL - 1);

    lane_state_e state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LS_STOP;
        else        state <= state_nx;
    end

    // Next state and timer loading
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            LS_STOP: begin
                if (hs_req && clk_lane_active) begin
                    state_nx = LS_LP_REQ;
                    tmr_load = 1'b1;
                    tmr_val  = LPX_M1;
                end
            end
            LS_LP_REQ: begin
                if (!hs_req) begin
                    state_nx = LS_STOP;
                end else if (tmr_expired) begin
                    state_nx = LS_LP_BRIDGE;
                    tmr_load = 1'b1;
                    tmr_val  = LPX_M1;
                end
            end
            LS_LP_BRIDGE: begin
                if (!hs_req) begin
                    state_nx = LS_STOP;
                end else if (tmr_expired) begin
                    state_nx = LS_HS_PREP;
                    tmr_load = 1'b1;
                    tmr_val  = PREP_M1;
                end
            end
            LS_HS_PREP: begin
                if (!hs_req) begin
                    state_nx = LS_STOP;
                end else if (tmr_expired) begin
                    state_nx = LS_HS_ZERO;
                    tmr_load = 1'b1;
                    tmr_val  = ZERO_M1;
                end
            end
            LS_HS_ZERO: begin
                if (!hs_req) begin
                    state_nx = LS_STOP;
                end else if (tmr_expired) begin
                    state_nx = LS_CDC_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = CDC_M1;
                end
            end
            LS_CDC_WAIT: begin
                if (!hs_req) begin
                    state_nx = LS_STOP;
                end else if (tmr_expired) begin
                    state_nx = LS_HS_DATA;
                end
            end
            LS_HS_DATA: begin
                if (!hs_req) begin
                    state_nx = LS_HS_TRAIL;
                    tmr_load = 1'b1;
                    tmr_val  = TRAIL_M1;
                end
            end
            LS_HS_TRAIL: begin
                if (tmr_expired) state_nx = LS_STOP;
            end
            default: state_nx = LS_STOP;
        endcase
    end

    // Outputs
    always_comb begin
        hs_ready = 1'b0;
        unique case (state)
            LS_HS_DATA: hs_ready = 1'b1;
            default:    hs_ready = 1'b0;
        endcase
        accept = hs_ready && hs_req;
    end

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_gate_clk_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(state) == LS_STOP && state == LS_LP_REQ) |-> $past(clk_lane_active));

    assert_abort_startup_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != LS_STOP && state != LS_HS_DATA && state != LS_HS_TRAIL && !hs_req)
        |=> state == LS_STOP);

    assert_ready_falls_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $fell(hs_ready)) |-> !$past(hs_req));

endmodule

// File: rtl/hs_lane_word_out.sv
module hs_lane_word_out #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accept,
    input  logic [W-1:0] in_word,
    output logic [W-1:0] out_word,
    output logic         out_valid
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= accept;
            if (accept) out_word <= in_word;
        end
    end

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_word_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && out_valid) |-> out_word == $past(in_word));

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !out_valid) |-> $stable(out_word));

endmodule

// File: rtl/hs_lane_tx.sv
module hs_lane_tx
    import hs_lane_pkg::*;
#(
    parameter int W       = 16,
    parameter int LPX     = 2,
    parameter int PREP    = 1,
    parameter int ZERO    = 3,
    parameter int CDC_FIX = 1,
    parameter int TRAIL   = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_lane_active,
    input  logic         hs_req,
    input  logic [W-1:0] hs_data,
    output logic         hs_ready,
    output logic [2:0]   lane_state,
    output logic [W-1:0] out_word,
    output logic         out_valid
);

    localparam int CDC_LEN = CDC_FIX + 2;
    localparam int MAX_A   = (LPX > PREP) ? LPX : PREP;
    localparam int MAX_B   = (ZERO > CDC_LEN) ? ZERO : CDC_LEN;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_D   = (MAX_C > TRAIL) ? MAX_C : TRAIL;
    localparam int CW      = (MAX_D < 2) ? 1 : $clog2(MAX_D);

    lane_state_e   st;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    logic          accept;

    hs_lane_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    hs_lane_seq #(
        .LPX     (LPX),
        .PREP    (PREP),
        .ZERO    (ZERO),
        .CDC_FIX (CDC_FIX),
        .TRAIL   (TRAIL),
        .CW      (CW)
    ) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .hs_req          (hs_req),
        .clk_lane_active (clk_lane_active),
        .tmr_expired     (tmr_expired),
        .state           (st),
        .tmr_load        (tmr_load),
        .tmr_val         (tmr_val),
        .hs_ready        (hs_ready),
        .accept          (accept)
    );

    hs_lane_word_out #(.W(W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .in_word   (hs_data),
        .out_word  (out_word),
        .out_valid (out_valid)
    );

    assign lane_state = st;

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_ready_after_cdc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(hs_ready)) |-> $past(lane_state) == 3'd5);

    assert_ready_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ready |-> lane_state == 3'd6);

    assert_trail_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(lane_state) == 3'd7 && lane_state != 3'd7) |-> lane_state == 3'd0);

    assert_valid_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && out_valid) |-> ($past(hs_req) && $past(hs_ready)));

endmodule

// File: tb/tb_hs_lane_tx.sv
`timescale 1ns/1ps
module tb_hs_lane_tx;

    localparam int W       = 16;
    localparam int LPX     = 2;
    localparam int PREP    = 1;
    localparam int ZERO    = 3;
    localparam int CDC_FIX = 1;
    localparam int TRAIL   = 2;
    localparam int TOTAL   = 2*LPX + PREP + ZERO + CDC_FIX + 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_lane_active = 1'b0;
    logic         hs_req = 1'b0;
    logic [W-1:0] hs_data = '0;
    logic         hs_ready;
    logic [2:0]   lane_state;
    logic [W-1:0] out_word;
    logic         out_valid;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] last_word = '0;

    always #10 clk = ~clk;

    hs_lane_tx #(.W(W), .LPX(LPX), .PREP(PREP), .ZERO(ZERO),
                 .CDC_FIX(CDC_FIX), .TRAIL(TRAIL)) dut (
        .clk(clk), .rst_n(rst_n), .clk_lane_active(clk_lane_active),
        .hs_req(hs_req), .hs_data(hs_data), .hs_ready(hs_ready),
        .lane_state(lane_state), .out_word(out_word), .out_valid(out_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected state code i edges after start-up began (i >= 1)
    function automatic logic [2:0] exp_state(input int i);
        int c;
        c = i - 1;
        if (c < LPX) return 3'd1;
        c -= LPX;
        if (c < LPX) return 3'd2;
        c -= LPX;
        if (c < PREP) return 3'd3;
        c -= PREP;
        if (c < ZERO) return 3'd4;
        c -= ZERO;
        if (c < CDC_FIX + 2) return 3'd5;
        return 3'd6;
    endfunction

    function automatic logic [W-1:0] pat(input int b, input int j);
        return W'(16'hA5C3 ^ (b * 16'h1111)) + W'(j * 16'h0107);
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic burst(input int b, input int len);
        int n;
        hs_req  = 1'b1;
        hs_data = pat(b, 0);
        n = 0;
        while (!hs_ready && n < TOTAL + 5) begin
            step();
            n++;
            if (!hs_ready) begin
                chk("R3 startup state", lane_state, exp_state(n));
                chk("R5 no output in startup", out_valid, 1'b0);
            end
        end
        chk("R3 ready latency", n, TOTAL + 1);
        chk("R4 data code", lane_state, 3'd6);
        for (int j = 0; j < len; j++) begin
            hs_data = pat(b, j);
            step();
            chk(len == 1 ? "R10 single word valid" : "R5 word valid", out_valid, 1'b1);
            chk(len == 1 ? "R10 single word value" : "R5 word order", out_word, pat(b, j));
            last_word = pat(b, j);
            if (j < len - 1) chk("R7 ready held", hs_ready, 1'b1);
        end
        hs_req  = 1'b0;
        hs_data = ~pat(b, 0);
        chk("R7 ready held in release cycle", hs_ready, 1'b1);
        step();
        chk("R7 ready dropped", hs_ready, 1'b0);
        chk("R6 no word after release", out_valid, 1'b0);
        chk("R8 trail code", lane_state, 3'd7);
        for (int t = 1; t < TRAIL; t++) begin
            hs_data = pat(b, 100 + t);
            step();
            chk("R8 trail held", lane_state, 3'd7);
            chk("R6 ignored in trail", out_word, last_word);
        end
        step();
        chk("R8 back to stop", lane_state, 3'd0);
        chk("R6 held value", out_word, last_word);
        chk("R6 no valid", out_valid, 1'b0);
    endtask

    task automatic abort_at(input int k);
        int seen_ready;
        seen_ready = 0;
        hs_req  = 1'b1;
        hs_data = pat(50, k);
        for (int i = 0; i < k; i++) begin
            step();
            if (hs_ready) seen_ready = 1;
        end
        hs_req = 1'b0;
        step();
        chk("R9 abort to stop", lane_state, 3'd0);
        chk("R9 ready never high", seen_ready | hs_ready, 1'b0);
        chk("R9 no word", out_valid, 1'b0);
        chk("R9 word unchanged", out_word, last_word);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", lane_state, 3'd0);
        chk("R1 reset ready", hs_ready, 1'b0);
        chk("R1 reset valid", out_valid, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R1 state after reset", lane_state, 3'd0);

        // Clock lane inactive: request ignored
        hs_req = 1'b1;
        hs_data = 16'h1234;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R2 gated by clock lane", lane_state, 3'd0);
            chk("R2 no ready", hs_ready, 1'b0);
        end
        hs_req = 1'b0;
        clk_lane_active = 1'b1;
        step();

        // Bursts of several lengths
        for (int len = 1; len <= 6; len++) begin
            burst(len, len);
            step();
        end

        // Abort at every start-up cycle
        for (int k = 1; k <= TOTAL; k++) begin
            abort_at(k);
            step();
        end

        // Data changes in STOP are ignored
        for (int i = 0; i < 4; i++) begin
            hs_data = pat(77, i);
            step();
            chk("R6 ignored in stop", out_valid, 1'b0);
            chk("R6 word held in stop", out_word, last_word);
        end

        burst(9, 3);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule